// File: doc/BRIEF.md
# Serial Transceiver with Receive-to-Transmit Turnaround Wait

This block is an 8-bit asynchronous serial transceiver for a half-duplex single-wire bus where one node answers right after it hears a frame. A single free-running tick generator drives both directions at 16 ticks per bit. The receiver samples every bit at mid-bit. The transmitter sends a start bit, eight data bits with the least significant bit first, and one or two stop bits. There is no parity bit.

Transmit data can enter through two ports. The immediate port starts a frame on the next tick, whatever the receiver is doing. If that happens while a received stop bit is still on the wire, the stop bit the bus sees is cut short. The deferred port fixes this during a turnaround. The transmitter holds the line high until one full bit period of receive stop has gone by, which is eight ticks after the stop-bit sample. It waits for one stop bit only, even when two are configured. The deferred port is legal only in bus mode and only while the transmitter is idle. Any other use of it is dropped and sets a sticky error flag.

Back-pressure works as follows. The immediate port accepts a beat when `tx_valid` and `tx_ready` are both high, and `tx_ready` is low for as long as `busy` is high. The deferred port always reports ready and consumes every beat, legal or not. When both ports are valid in one cycle, the immediate port wins and the deferred beat counts as illegal. A received byte stays on `rx_data` with `rx_valid` high until a cycle with `rx_ready` high. A later frame overwrites a byte that has not been taken.

Top module: `lin_turnaround_uart`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `rx_valid` is 0, `illegal_flag` is 0 and `tx_ready` is 1.
- R2: A transmitted frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit, or two when `cfg_two_stop` is 1 at launch. Each bit lasts 16 ticks, which is 16*TICK_DIV clocks.
- R3: A beat accepted on the immediate port puts the start bit on `txd` at the next tick, whatever the state of the receiver.
- R4: `busy` rises the cycle after a beat is accepted and stays high until the last stop bit has ended. `txd` is 1 whenever `busy` is 0 and while a deferred start is waiting.
- R5: The receiver samples `rxd` at mid-bit and needs a high first stop bit. The byte is held on `rx_data` with `rx_valid` high until `rx_ready`, and a newer frame overwrites an untaken byte.
- R6: A legal deferred write made while a frame is being received starts the start bit 8 ticks after the stop-bit sample, so the bus sees one full bit of stop.
- R7: With `cfg_two_stop` = 1, the deferred start still waits for only one receive stop bit.
- R8: A legal deferred write made while the receiver is idle and its stop bit has fully ended starts on the next tick.
- R9: A deferred write while `cfg_lin_en` = 0 is ignored: no frame and no change to `busy`. It sets `illegal_flag`.
- R10: A deferred write while `busy` = 1 is ignored, which leaves the frame in progress unchanged, and it sets `illegal_flag`.
- R11: `illegal_flag` stays set until a cycle with `illegal_clr` high. If an illegal write arrives in that same cycle, the set wins.
- R12: While `busy` = 1, `tx_ready` is 0 and a beat on the immediate port is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lin_en | input | 1 | Bus (turnaround) mode enable; the deferred port is legal only when this is 1 |
| cfg_two_stop | input | 1 | 1 selects two stop bits per frame |
| tx_data | input | 8 | Transmit byte, shared by both ports |
| tx_valid | input | 1 | Immediate-port beat valid |
| tx_ready | output | 1 | Immediate port can accept a beat |
| txw_valid | input | 1 | Deferred-port beat valid |
| txw_ready | output | 1 | Deferred port ready; always 1 |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Consumer takes the received byte |
| busy | output | 1 | A transmit start is pending or a frame is being sent |
| illegal_flag | output | 1 | Sticky flag for an illegal deferred write |
| illegal_clr | input | 1 | Clears `illegal_flag` |

## Verification
All 256 byte values go out through the immediate port, with `txd` looped back to `rxd`. This separates bit-order and framing faults in the transmitter from sampling faults in the receiver. Deferred writes are placed at several points of an incoming frame: the start bit, the data bits, the stop bit before its sample, and after `rx_valid`. The gap between the rising edge of the receive stop bit and the falling edge of the transmit start bit must always be one bit. Repeating this with two stop bits shows the wait is not doubled. The immediate port gives a visibly shorter gap in the same situation. Deferred writes while the receiver is idle, with bus mode off, while busy, and in the same cycle as the clear strobe each check a different branch of the legality and release logic.

// File: rtl/lta_pkg.sv
package lta_pkg;
  localparam int OVS  = 16;
  localparam int HALF = OVS / 2;
  localparam int CW   = $clog2(OVS);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {ARM_NONE, ARM_NOW, ARM_WAIT} arm_state_e;
endpackage

// File: rtl/lta_tick_gen.sv
module lta_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/lta_rx.sv
module lta_rx
  import lta_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              in_frame,
  output logic              stop_seen
);
  localparam int BW = $clog2(DATA_W);

  logic [1:0]        sync_q;
  logic              rxs;
  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              mid, bound;

  assign rxs       = sync_q[1];
  assign mid       = tick && (cnt == CW'(HALF - 1));
  assign bound     = tick && (cnt == CW'(OVS - 1));
  assign in_frame  = (state != RX_IDLE);
  assign stop_seen = mid && (state == RX_STOP) && rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_ready) rx_valid <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE) begin
          if (!rxs) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      case (state)
        RX_START: begin
          if (mid && rxs) state <= RX_IDLE;
          else if (bound) begin
            state <= RX_DATA;
            bitn  <= '0;
          end
        end
        RX_DATA: begin
          if (mid) sh <= {rxs, sh[DATA_W-1:1]};
          if (bound) begin
            if (bitn == BW'(DATA_W - 1)) state <= RX_STOP;
            else                         bitn  <= bitn + 1'b1;
          end
        end
        RX_STOP: begin
          if (mid) begin
            state <= RX_IDLE;
            if (rxs) begin
              rx_data  <= sh;
              rx_valid <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lta_tx.sv
module lta_tx
  import lta_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  logic [DATA_W-1:0] launch_data,
  input  logic              two_stop,
  output logic              txd,
  output logic              sending
);
  localparam int SW = DATA_W + 2;
  localparam int LW = $clog2(DATA_W + 3);

  logic [SW-1:0] sh;
  logic [LW-1:0] left;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd     <= 1'b1;
      sending <= 1'b0;
      sh      <= '1;
      left    <= '0;
      cnt     <= '0;
    end else if (launch) begin
      sending <= 1'b1;
      txd     <= 1'b0;
      cnt     <= '0;
      sh      <= {2'b11, launch_data};
      left    <= LW'(DATA_W + 1) + {{(LW-1){1'b0}}, two_stop};
    end else if (sending && tick) begin
      if (cnt == CW'(OVS - 1)) begin
        cnt <= '0;
        if (left == '0) begin
          sending <= 1'b0;
          txd     <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[SW-1:1]};
          left <= left - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lta_launch_ctrl.sv
module lta_launch_ctrl
  import lta_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_lin_en,
  input  logic              tx_valid,
  input  logic              txw_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_sending,
  input  logic              rx_in_frame,
  input  logic              rx_stop_seen,
  input  logic              illegal_clr,
  output logic              tx_ready,
  output logic              busy,
  output logic              launch,
  output logic [DATA_W-1:0] launch_data,
  output logic              illegal_flag
);
  localparam int RW = $clog2(HALF + 1);

  arm_state_e    arm;
  logic [RW-1:0] rem;
  logic          take_now, take_wait, bad_wait, quiet;

  assign busy      = (arm != ARM_NONE) || tx_sending;
  assign tx_ready  = !busy;
  assign take_now  = tx_valid && !busy;
  assign take_wait = txw_valid && cfg_lin_en && !busy && !tx_valid;
  assign bad_wait  = txw_valid && !take_wait;
  assign quiet     = !rx_in_frame && (rem <= RW'(1));
  assign launch    = tick && ((arm == ARM_NOW) || ((arm == ARM_WAIT) && quiet));

  // Holdoff: remaining ticks of the receive stop bit after its sample point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rem <= '0;
    else if (rx_stop_seen)       rem <= RW'(HALF);
    else if (tick && rem != '0)  rem <= rem - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm         <= ARM_NONE;
      launch_data <= '0;
    end else if (launch) begin
      arm <= ARM_NONE;
    end else if (take_now) begin
      arm         <= ARM_NOW;
      launch_data <= tx_data;
    end else if (take_wait) begin
      arm         <= ARM_WAIT;
      launch_data <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           illegal_flag <= 1'b0;
    else if (bad_wait)    illegal_flag <= 1'b1;
    else if (illegal_clr) illegal_flag <= 1'b0;
  end
endmodule

// File: rtl/lin_turnaround_uart.sv
module lin_turnaround_uart #(
  parameter int TICK_DIV = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lin_en,
  input  logic              cfg_two_stop,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              txw_valid,
  output logic              txw_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              busy,
  output logic              illegal_flag,
  input  logic              illegal_clr
);
  logic              tick;
  logic              rx_in_frame, rx_stop_seen;
  logic              launch, tx_sending;
  logic [DATA_W-1:0] launch_data;

  assign txw_ready = 1'b1;

  lta_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lta_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .in_frame(rx_in_frame), .stop_seen(rx_stop_seen)
  );

  lta_launch_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_lin_en(cfg_lin_en),
    .tx_valid(tx_valid), .txw_valid(txw_valid), .tx_data(tx_data),
    .tx_sending(tx_sending), .rx_in_frame(rx_in_frame),
    .rx_stop_seen(rx_stop_seen), .illegal_clr(illegal_clr),
    .tx_ready(tx_ready), .busy(busy), .launch(launch),
    .launch_data(launch_data), .illegal_flag(illegal_flag)
  );

  lta_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .launch(launch),
    .launch_data(launch_data), .two_stop(cfg_two_stop),
    .txd(txd), .sending(tx_sending)
  );
endmodule

// File: rtl/lin_turnaround_uart_chk.sv
module lin_turnaround_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_lin_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic txw_valid,
  input logic txd,
  input logic busy,
  input logic rx_valid,
  input logic rx_ready,
  input logic illegal_flag,
  input logic illegal_clr
);
  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);
  assert_no_ready_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tx_ready);
  assert_wait_lin_off_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txw_valid && !cfg_lin_en) |=> illegal_flag);
  assert_wait_lin_off_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txw_valid && !cfg_lin_en && !busy && !tx_valid) |=> !busy);
  assert_wait_busy_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txw_valid && busy) |=> illegal_flag);
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_flag && !illegal_clr) |=> illegal_flag);
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_clr && !txw_valid) |=> !illegal_flag);
  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind lin_turnaround_uart lin_turnaround_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_lin_en(cfg_lin_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txw_valid(txw_valid), .txd(txd), .busy(busy),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .illegal_flag(illegal_flag),
  .illegal_clr(illegal_clr)
);

// File: tb/tb_lin_turnaround_uart.sv
`timescale 1ns/1ps
module tb_lin_turnaround_uart;
  localparam int TDIV = 2;
  localparam int BIT  = 16 * TDIV;
  localparam int WD   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_lin_en = 1'b1, cfg_two_stop = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0, txw_valid = 1'b0;
  logic       tx_ready, txw_ready, txd, busy, illegal_flag, rx_valid;
  logic       illegal_clr = 1'b0, rx_ready = 1'b1;
  logic       loop_en = 1'b0, rx_drv = 1'b1;
  logic       rxd;
  logic [7:0] rx_data;

  int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
  logic [7:0] last_rx = '0;

  assign rxd = loop_en ? txd : rx_drv;

  always #2 clk = ~clk;

  lin_turnaround_uart #(.TICK_DIV(TDIV), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lin_en(cfg_lin_en), .cfg_two_stop(cfg_two_stop),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txw_valid(txw_valid), .txw_ready(txw_ready), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .busy(busy),
    .illegal_flag(illegal_flag), .illegal_clr(illegal_clr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n && rx_valid && rx_ready) begin
    last_rx <= rx_data;
    rx_cnt  <= rx_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_now(input logic [7:0] d, output int w);
    @(negedge clk); tx_data = d; tx_valid = 1'b1; w = cyc;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wr_wait(input logic [7:0] d, input bit clr, output int w);
    @(negedge clk); tx_data = d; txw_valid = 1'b1; illegal_clr = clr; w = cyc;
    @(negedge clk); txw_valid = 1'b0; illegal_clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); illegal_clr = 1'b1;
    @(negedge clk); illegal_clr = 1'b0;
  endtask

  task automatic cap_tx(input bit two, output logic [7:0] d, output int tf);
    int n = 0;
    tf = -1; d = '0;
    while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    if (txd !== 1'b0) begin chk(1'b0, "R2", "no start bit", 1, 0); return; end
    tf = cyc;
    repeat (BIT/2) @(negedge clk);
    chk(txd == 1'b0, "R2", "start bit level", txd, 0);
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); d[i] = txd; end
    repeat (BIT) @(negedge clk);
    chk(txd == 1'b1, "R2", "first stop level", txd, 1);
    if (two) begin
      repeat (BIT) @(negedge clk);
      chk(txd == 1'b1, "R2", "second stop level", txd, 1);
    end
    chk(busy == 1'b1, "R4", "busy in last stop", busy, 1);
    repeat (BIT/2 + 4) @(negedge clk);
    chk(busy == 1'b0, "R4", "busy after frame", busy, 0);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit two, output int tstop);
    @(negedge clk); rx_drv = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; repeat (BIT) @(negedge clk); end
    rx_drv = 1'b1; tstop = cyc;
    repeat (two ? 2*BIT : BIT) @(negedge clk);
  endtask

  task automatic watch_idle(input int n, output bit act);
    act = 1'b0;
    repeat (n) begin @(negedge clk); if (txd == 1'b0 || busy) act = 1'b1; end
  endtask

  initial begin
    logic [7:0] d;
    int w, tf, ts, gap, c0;
    bit act;
    int offs [4] = '{10, 100, 250, 295};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd idle", txd, 1);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(illegal_flag == 1'b0, "R1", "illegal_flag", illegal_flag, 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);

    // R3 immediate start, R12 refusal while busy
    fork
      begin wr_now(8'h3C, w); cap_tx(1'b0, d, tf); end
      begin
        repeat (80) @(negedge clk);
        chk(tx_ready == 1'b0, "R12", "tx_ready while busy", tx_ready, 0);
        wr_now(8'h99, c0);
      end
    join
    chk(tf - w >= 1 && tf - w <= TDIV + 2, "R3", "start latency", tf - w, TDIV + 1);
    chk(d == 8'h3C, "R12", "frame kept", d, 8'h3C);
    watch_idle(200, act);
    chk(!act, "R12", "refused beat sent no frame", act, 0);

    // R10 deferred write while busy
    fork
      begin wr_now(8'h5A, w); cap_tx(1'b0, d, tf); end
      begin repeat (120) @(negedge clk); wr_wait(8'hE7, 1'b0, c0); end
    join
    chk(d == 8'h5A, "R10", "frame unchanged", d, 8'h5A);
    chk(illegal_flag == 1'b1, "R10", "flag set", illegal_flag, 1);
    watch_idle(200, act);
    chk(!act, "R10", "no extra frame", act, 0);
    chk(illegal_flag == 1'b1, "R11", "flag sticky", illegal_flag, 1);
    pulse_clr();
    chk(illegal_flag == 1'b0, "R11", "flag cleared", illegal_flag, 0);

    // R9 deferred write with bus mode off
    cfg_lin_en = 1'b0;
    wr_wait(8'h77, 1'b0, w);
    chk(illegal_flag == 1'b1, "R9", "flag set", illegal_flag, 1);
    watch_idle(200, act);
    chk(!act, "R9", "write ignored", act, 0);
    wr_wait(8'h11, 1'b1, w);
    chk(illegal_flag == 1'b1, "R11", "set wins over clear", illegal_flag, 1);
    pulse_clr();
    chk(illegal_flag == 1'b0, "R11", "cleared again", illegal_flag, 0);
    cfg_lin_en = 1'b1;

    // R8 deferred write with receiver idle
    wr_wait(8'hC3, 1'b0, w);
    cap_tx(1'b0, d, tf);
    chk(tf - w >= 1 && tf - w <= TDIV + 2, "R8", "idle start latency", tf - w, TDIV + 1);
    chk(d == 8'hC3, "R8", "data", d, 8'hC3);
    send_rx(8'h2D, 1'b0, ts);
    repeat (60) @(negedge clk);
    wr_wait(8'h4B, 1'b0, w);
    cap_tx(1'b0, d, tf);
    chk(tf - w >= 1 && tf - w <= TDIV + 2, "R8", "after stop latency", tf - w, TDIV + 1);
    chk(last_rx == 8'h2D, "R5", "rx byte", last_rx, 8'h2D);

    // R6 turnaround from several write points
    for (int k = 0; k < 5; k++) begin
      logic [7:0] rb, tb;
      rb = 8'h4E ^ 8'(k * 37); tb = 8'hB1 + 8'(k);
      fork
        send_rx(rb, 1'b0, ts);
        begin
          if (k < 4) repeat (offs[k]) @(negedge clk);
          else begin
            repeat (2) @(negedge clk);
            while (!rx_valid) @(negedge clk);
          end
          wr_wait(tb, 1'b0, w);
          repeat (2) @(negedge clk);
          chk(busy && txd, "R4", "line high while waiting", {busy, txd}, 3);
          cap_tx(1'b0, d, tf);
        end
      join
      gap = tf - ts;
      chk(gap >= BIT && gap <= BIT + 8, "R6", "stop length seen", gap, BIT + 4);
      chk(d == tb, "R6", "data", d, tb);
      chk(last_rx == rb, "R5", "rx byte", last_rx, rb);
      repeat (40) @(negedge clk);
    end

    // R7 two stop bits: still one bit of wait
    cfg_two_stop = 1'b1;
    fork
      send_rx(8'h6C, 1'b1, ts);
      begin repeat (100) @(negedge clk); wr_wait(8'h93, 1'b0, w); cap_tx(1'b1, d, tf); end
    join
    gap = tf - ts;
    chk(gap >= BIT && gap <= BIT + 8, "R7", "single stop wait", gap, BIT + 4);
    chk(d == 8'h93, "R7", "data", d, 8'h93);
    cfg_two_stop = 1'b0;
    repeat (40) @(negedge clk);

    // R3 immediate port during receive stop shortens the stop
    fork
      send_rx(8'h81, 1'b0, ts);
      begin
        repeat (2) @(negedge clk);
        while (!rx_valid) @(negedge clk);
        wr_now(8'h18, w);
        cap_tx(1'b0, d, tf);
      end
    join
    gap = tf - ts;
    chk(gap < BIT - 4, "R3", "immediate start ignores receiver", gap, BIT / 2);
    repeat (40) @(negedge clk);

    // R5 hold and overwrite
    rx_ready = 1'b0;
    send_rx(8'h96, 1'b0, ts);
    repeat (30) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h96, "R5", "held byte", rx_data, 8'h96);
    send_rx(8'h2B, 1'b0, ts);
    repeat (30) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 8'h2B, "R5", "overwritten byte", rx_data, 8'h2B);
    rx_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R5", "taken", rx_valid, 0);

    // R2 loopback sweep over all bytes
    loop_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      c0 = rx_cnt;
      wr_now(8'(v), w);
      cap_tx(1'b0, d, tf);
      chk(d == 8'(v), "R2", "sweep data", d, v);
      chk(rx_cnt == c0 + 1 && last_rx == 8'(v), "R5", "loopback byte", last_rx, v);
    end
    cfg_two_stop = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] b;
      b = 8'(1 << v) ^ 8'hA5;
      wr_now(b, w);
      cap_tx(1'b1, d, tf);
      chk(d == b, "R2", "two stop data", d, b);
      chk(last_rx == b, "R5", "two stop loopback", last_rx, b);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule